// File: doc/BRIEF.md
# Spill-Gated Event Buffer

This block holds complete detector event records in on-board memory while a particle beam is delivering a spill, and hands them to the host once the spill is over. A trigger arms the capture path. The following front-end words, framed by start and end markers, are stored behind a reserved header slot. After the end marker, the header is written with the trigger number and the stored length. The buffer is a circular word memory whose write and read pointers wrap modulo its depth. A complete-event count tracks how many events are stored and not yet fully read.

Three operating modes decide when the host sees what. In single-trigger mode, each event must be drained before another trigger is taken, and reads are allowed during the spill. In semi-buffered mode, a one-cycle summary carrying the trigger number and the buffer occupancy is offered for each completed event, while the data stays in memory until the spill ends. In fully-buffered mode, nothing is offered per trigger. The block reports busy when less than one maximum-size event of space is left, and a sticky overflow flag records a trigger that arrived while busy.

Top module: `spill_event_buffer`

## Requirements
- R1: Reset clears the write and read pointers, the occupancy, the used-word count, the trigger number and the overflow flag, so that busy, overflow, read-valid and summary-valid are all low.
- R2: A trigger is accepted only when beam-on is high, no capture is in progress and busy is low. Accepted triggers are numbered 0, 1, 2 and so on, and rejected triggers consume no number. Each stored event is one header word followed by its data words in arrival order. The header holds the trigger number in bits 31:16 and the data-word count in bits 15:0.
- R3: Only words arriving after an accepted trigger are stored. Words before the first start-marked word are dropped, and storage ends with the end-marked word. Words beyond MAX_EVT_WORDS-1 data words are dropped, and the header length counts only the stored words. Input words while no event is armed have no effect.
- R4: Occupancy counts events that are complete and not fully read. It rises on the second clock edge after the end-marked word and falls when the last data word of the event at the read pointer is popped. Read-valid is never high while occupancy is zero.
- R5: In the semi-buffered (mode 1) and fully-buffered (modes 2 and 3) modes, read-valid is high only when beam-on is low and occupancy is non-zero. A pop happens when read-enable and read-valid are both high, and the read data shows the word at the read pointer.
- R6: In single-trigger mode (mode 0), reads are allowed regardless of beam-on. A trigger arriving while occupancy is non-zero is ignored without setting overflow.
- R7: In semi-buffered mode, summary-valid pulses for exactly one cycle on the same edge that raises occupancy. With the pulse, the summary outputs give that event's trigger number and the occupancy that includes it.
- R8: In single-trigger and fully-buffered modes, summary-valid stays low.
- R9: Busy is high exactly when DEPTH minus the stored, unpopped word count (headers included) is less than MAX_EVT_WORDS.
- R10: A trigger arriving while busy is not accepted and sets overflow, which stays high until reset.
- R11: Write and read pointers wrap modulo DEPTH, and events stored across the end of memory read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 single-trigger, 1 semi-buffered, 2/3 fully-buffered |
| beam_on_i | input | 1 | Spill in progress |
| trig_i | input | 1 | Trigger pulse |
| in_valid_i | input | 1 | Capture word valid |
| in_sop_i | input | 1 | First word of event |
| in_eop_i | input | 1 | Last word of event |
| in_data_i | input | DATA_W | Capture word |
| rd_en_i | input | 1 | Pop the word at the read pointer |
| rd_valid_o | output | 1 | A word may be read |
| rd_data_o | output | DATA_W | Word at the read pointer |
| occupancy_o | output | ADDR_W+1 | Complete events not yet read |
| busy_o | output | 1 | Less than one maximum event of space left |
| overflow_o | output | 1 | Sticky trigger-while-busy flag |
| sum_valid_o | output | 1 | Semi-buffered summary pulse |
| sum_trig_o | output | 16 | Summary trigger number |
| sum_occ_o | output | ADDR_W+1 | Summary occupancy |

## Verification
The bench targets truncation of an over-long event, with junk words before the start marker. A design that mis-counts here writes a wrong header length, and every later read is then misaligned. It fills the buffer to the exact busy threshold and fires one more trigger. An off-by-one in the free-space test either refuses a legal event or accepts one that has no room, and a missing overflow flag hides the lost trigger. A second trigger in single-trigger mode must neither consume a trigger number nor raise overflow. Enough traffic runs to wrap both pointers, and a pointer that does not wrap cleanly returns scrambled data after the memory end.

// File: rtl/spill_event_buffer.sv
module spill_event_buffer #(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 11,
  parameter int MAX_EVT_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              beam_on_i,
  input  logic              trig_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W:0]   occupancy_o,
  output logic              busy_o,
  output logic              overflow_o,
  output logic              sum_valid_o,
  output logic [15:0]       sum_trig_o,
  output logic [ADDR_W:0]   sum_occ_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OCC_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(MAX_EVT_WORDS);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_EVT_WORDS - 1);
  localparam logic [OCC_W:0]   DEPTH_X = (OCC_W+1)'(DEPTH);
  localparam logic [OCC_W:0]   MAX_X   = (OCC_W+1)'(MAX_EVT_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAPT, S_HDR} state_t;

  state_t            st;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, hdr_ptr;
  logic [CNT_W-1:0]  wcnt;
  logic [OCC_W-1:0]  used, occ, occ_next, used_next;
  logic [15:0]       rd_left, trig_num, cur_trig;
  logic [DATA_W-1:0] hdr_word;

  wire single  = (mode_i == 2'd0);
  wire semi    = (mode_i == 2'd1);
  wire accept  = trig_i && beam_on_i && st == S_IDLE && !busy_o && !(single && occ != '0);
  wire cap     = in_valid_i && ((st == S_WAIT && in_sop_i) || st == S_CAPT);
  wire room    = wcnt < LEN_MAX;
  wire wr_data = cap && room;
  wire hdr_wr  = (st == S_HDR);
  wire pop     = rd_en_i && rd_valid_o;
  wire rd_last = pop && rd_left == 16'd1;
  wire [ADDR_W-1:0] wr_addr = hdr_ptr + ADDR_W'(1) + ADDR_W'(wcnt);

  assign busy_o      = ({1'b0, used} + MAX_X) > DEPTH_X;
  assign rd_valid_o  = (occ != '0) && (single || !beam_on_i);
  assign rd_data_o   = mem[rd_ptr];
  assign occupancy_o = occ;
  assign occ_next    = occ + OCC_W'(hdr_wr) - OCC_W'(rd_last);
  assign used_next   = used + (hdr_wr ? OCC_W'(wcnt) + OCC_W'(1) : '0) - OCC_W'(pop);

  always_comb begin
    hdr_word        = '0;
    hdr_word[31:16] = cur_trig;
    hdr_word[15:0]  = 16'(wcnt);
  end

  always_ff @(posedge clk) begin
    if (wr_data) mem[wr_addr] <= in_data_i;
    if (hdr_wr)  mem[hdr_ptr] <= hdr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_ptr   <= '0;
      hdr_ptr  <= '0;
      wcnt     <= '0;
      cur_trig <= '0;
      trig_num <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_WAIT;
          hdr_ptr  <= wr_ptr;
          wcnt     <= '0;
          cur_trig <= trig_num;
          trig_num <= trig_num + 16'd1;
        end
        S_WAIT, S_CAPT: if (cap) begin
          if (room) wcnt <= wcnt + CNT_W'(1);
          st <= in_eop_i ? S_HDR : S_CAPT;
        end
        S_HDR: begin
          wr_ptr <= wr_addr;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_left <= '0;
      occ     <= '0;
      used    <= '0;
    end else begin
      occ  <= occ_next;
      used <= used_next;
      if (pop) begin
        rd_ptr  <= rd_ptr + ADDR_W'(1);
        rd_left <= (rd_left == 16'd0) ? rd_data_o[15:0] : rd_left - 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow_o  <= 1'b0;
      sum_valid_o <= 1'b0;
      sum_trig_o  <= '0;
      sum_occ_o   <= '0;
    end else begin
      if (trig_i && busy_o) overflow_o <= 1'b1;
      sum_valid_o <= hdr_wr && semi;
      if (hdr_wr && semi) begin
        sum_trig_o <= cur_trig;
        sum_occ_o  <= occ_next;
      end
    end
  end
endmodule

// File: rtl/spill_event_buffer_chk.sv
module spill_event_buffer_chk #(
  parameter int OCC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             beam_on_i,
  input logic             trig_i,
  input logic             rd_valid_o,
  input logic [OCC_W-1:0] occupancy_o,
  input logic             busy_o,
  input logic             overflow_o,
  input logic             sum_valid_o
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R10
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(trig_i && busy_o)); // R10
  AST_SPILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_on_i && mode_i != 2'd0) |-> !rd_valid_o); // R5
  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy_o == '0) |-> !rd_valid_o); // R4
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occupancy_o == $past(occupancy_o) || occupancy_o == $past(occupancy_o) + 1'b1
              || occupancy_o == $past(occupancy_o) - 1'b1)); // R4
  AST_SUM_SEMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |-> $past(mode_i) == 2'd1); // R8
  AST_SUM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |=> !sum_valid_o); // R7
endmodule

bind spill_event_buffer spill_event_buffer_chk #(.OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .beam_on_i(beam_on_i), .trig_i(trig_i),
  .rd_valid_o(rd_valid_o), .occupancy_o(occupancy_o), .busy_o(busy_o),
  .overflow_o(overflow_o), .sum_valid_o(sum_valid_o)
);

// File: tb/spill_event_buffer_bench.sv
`timescale 1ns/1ps
module spill_event_buffer_bench;
  localparam int DW = 32, AW = 5, MAXW = 8, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic beam = 1'b0, trig = 1'b0, vld = 1'b0, sop = 1'b0, eop = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic rd_valid, busy, ovf, sum_valid;
  logic [DW-1:0] rd_data;
  logic [AW:0] occ, sum_occ;
  logic [15:0] sum_trig;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  int exp_trig = 0, exp_occ = 0, exp_used = 0;
  bit exp_ovf = 0;

  always #2.5 clk = ~clk;

  spill_event_buffer #(.DATA_W(DW), .ADDR_W(AW), .MAX_EVT_WORDS(MAXW)) u_spill_event_buffer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .beam_on_i(beam), .trig_i(trig),
    .in_valid_i(vld), .in_sop_i(sop), .in_eop_i(eop), .in_data_i(din),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .occupancy_o(occ),
    .busy_o(busy), .overflow_o(ovf), .sum_valid_o(sum_valid), .sum_trig_o(sum_trig),
    .sum_occ_o(sum_occ));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_busy();
    return (DEPTH - exp_used) < MAXW;
  endfunction

  task automatic status(string req);
    chk({req, " occupancy"}, 32'(occ), 32'(exp_occ));
    chk({req, " busy"}, 32'(busy), 32'(exp_busy()));
    chk({req, " overflow"}, 32'(ovf), 32'(exp_ovf));
  endtask

  task automatic send(int n, bit junk);
    bit acc;
    int len;
    acc = beam && !exp_busy() && !(mode == 2'd0 && exp_occ != 0);
    len = (n < MAXW - 1) ? n : MAXW - 1;
    trig = 1'b1; tick(); trig = 1'b0;
    if (junk) begin vld = 1'b1; din = 32'hBAD0_0000; tick(); end
    for (int i = 0; i < n; i++) begin
      vld = 1'b1; sop = (i == 0); eop = (i == n - 1);
      din = 32'hC0DE_0000 | (exp_trig << 8) | i;
      tick();
    end
    vld = 1'b0; sop = 1'b0; eop = 1'b0;
    tick();
    if (acc) begin
      exp_q.push_back({16'(exp_trig), 16'(len)});
      for (int i = 0; i < len; i++) exp_q.push_back(32'hC0DE_0000 | (exp_trig << 8) | i);
      exp_trig++; exp_occ++; exp_used += len + 1;
    end else if (exp_busy()) exp_ovf = 1;
    status(acc ? "R2 R4 stored" : "R10 R6 rejected");
    if (mode == 2'd1 && acc) begin
      chk("R7 sum valid", 32'(sum_valid), 1);
      chk("R7 sum trig", 32'(sum_trig), 32'(exp_trig - 1));
      chk("R7 sum occ", 32'(sum_occ), 32'(exp_occ));
    end else chk("R8 no summary", 32'(sum_valid), 0);
  endtask

  task automatic drain_event();
    int len;
    len = int'(exp_q[0][15:0]);
    for (int k = 0; k <= len; k++) begin
      chk("R5 R6 read valid", 32'(rd_valid), 1);
      chk("R2 R11 read data", rd_data, exp_q.pop_front());
      rd_en = 1'b1; tick();
    end
    rd_en = 1'b0;
    exp_used -= len + 1; exp_occ--;
    status("R4 after drain");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    exp_q.delete(); exp_trig = 0; exp_occ = 0; exp_used = 0; exp_ovf = 0;
    status("R1 reset");
    chk("R1 read valid", 32'(rd_valid), 0);
    chk("R1 sum valid", 32'(sum_valid), 0);
  endtask

  initial begin
    tick();
    do_reset();

    mode = 2'd2; beam = 1'b1;
    for (int n = 1; n <= 3; n++) send(n, 0);
    send(9, 1);  // R3 junk before start plus truncation to MAXW-1
    chk("R5 no read during spill", 32'(rd_valid), 0);
    vld = 1'b1; din = 32'hFFFF_FFFF; tick(); tick(); vld = 1'b0; tick();
    status("R3 stray words ignored");
    beam = 1'b0; tick();
    trig = 1'b1; tick(); trig = 1'b0; tick();
    status("R2 trigger without beam ignored");
    while (exp_q.size() > 0) drain_event();
    chk("R4 empty no read", 32'(rd_valid), 0);

    mode = 2'd1; beam = 1'b1;
    for (int e = 0; e < 5; e++) send(5, 0);
    chk("R9 busy at threshold", 32'(busy), 1);
    chk("R5 semi no read during spill", 32'(rd_valid), 0);
    send(2, 0);  // R10 trigger while busy
    beam = 1'b0; tick();
    drain_event();
    drain_event();
    chk("R10 overflow sticky", 32'(ovf), 1);
    do_reset();

    mode = 2'd0; beam = 1'b1;
    send(3, 0);
    send(2, 0);  // R6 ignored while an event is pending
    chk("R6 no overflow", 32'(ovf), 0);
    drain_event();
    send(2, 0);
    drain_event();
    for (int e = 0; e < 6; e++) begin send(4, 0); drain_event(); end  // R11 wrap
    chk("R6 final occupancy", 32'(occ), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule